// File: doc/BRIEF.md
# Byte-Window Register Bridge

This bridge sits behind a byte-oriented access port, such as the one a two-wire serial slave presents once it has decoded its address and data bytes. It turns that port's 8-bit reads and writes into indirect accesses to a 16-bit management register space, which is addressed by a device ID and a 16-bit register address. The 256 byte addresses fall into two halves. The lower half holds three pointer bytes: the device ID and the two bytes of a base register address. The upper half is a window onto 64 consecutive 16-bit registers that start at the base address. The upper byte of each register sits at the even byte address and the lower byte at the odd one.

A 16-bit write is assembled from two byte writes. The even byte is staged, and one register write carrying both bytes goes out when the odd byte arrives. A read of the even byte fetches the whole register and keeps its lower half, so the odd read that follows returns a value from the same register read. The register space flags which addresses exist. Registers that do not exist, and device IDs the bridge does not support, read as zero. Accesses to an unsupported device never reach the register bus. Read data is registered and appears on `byte_rdata` in the cycle after the read strobe.

Top module: `bwin_bridge`

## Requirements
- R1: After reset the three pointer bytes are 0, `byte_rdata` is 0, and neither `mgmt_we` nor `mgmt_re` is asserted until a window access is made.
- R2: Byte address 7Dh holds the device ID, 7Eh the upper base-address byte and 7Fh the lower base-address byte. Each can be written and read back, and read data appears on `byte_rdata` one cycle after the read strobe.
- R3: Byte addresses 0 to 124 read as 0. Writes to them change no pointer byte and cause no register-bus access.
- R4: A byte address b of 128 or above reaches register base + (b−128)/2, computed modulo 2^16, on `mgmt_addr`, with the pointer device ID on `mgmt_dev`.
- R5: A write to an even window byte only stages that byte, with no bus write. A write to the odd byte of the pair issues one `mgmt_we` cycle with data {staged byte, odd byte}.
- R6: A read of an even window byte issues one `mgmt_re` cycle and returns bits 15:8. It also latches bits 7:0, and a later odd-byte read returns that latched byte without a bus read, even if the register has changed since.
- R7: When the register space reports `mgmt_hit` low for a read, the bridge returns 0 for both bytes of that register, whatever is on `mgmt_rdata`.
- R8: Device IDs 1, 3 and 4 are supported. ID 2 is supported only when parameter `DEV2_EN` is 1 (default 0). With an unsupported ID, window accesses assert no bus strobe and read as 0.
- R9: If the read and write strobes are asserted in the same cycle, the write takes effect and the read is ignored: `byte_rdata` keeps its previous value and no `mgmt_re` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| byte_addr | input | 8 | Byte address of the current access |
| byte_wdata | input | 8 | Byte write data |
| byte_wr | input | 1 | Byte write strobe, one cycle per access |
| byte_rd | input | 1 | Byte read strobe, one cycle per access |
| byte_rdata | output | 8 | Registered read data, valid the cycle after `byte_rd` |
| mgmt_dev | output | 8 | Target device ID |
| mgmt_addr | output | 16 | Target register address |
| mgmt_wdata | output | 16 | Register write data |
| mgmt_we | output | 1 | Register write enable |
| mgmt_re | output | 1 | Register read strobe |
| mgmt_rdata | input | 16 | Register read data, combinational response to `mgmt_re` |
| mgmt_hit | input | 1 | High when the addressed register exists |

## Verification
The bench stages an upper byte and checks that no bus write leaves before the odd byte. A bridge that wrote on every byte would break this check. It then overwrites a register between the even and odd reads. A bridge that re-read on the odd byte would return the new lower half, not the latched one. It drives non-zero data with `mgmt_hit` low, which catches a bridge that passes miss data through. It also sets device ID 2, which catches a bridge that lets that ID through. A base of FFFFh checks that the address wraps. Simultaneous read and write strobes check that the read really is dropped.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

  // Class of a byte address as seen by the bridge
  typedef enum logic [2:0] {
    BK_RSVD = 3'd0,
    BK_DEV  = 3'd1,
    BK_BHI  = 3'd2,
    BK_BLO  = 3'd3,
    BK_WIN  = 3'd4
  } bkind_e;

endpackage

// File: rtl/bwin_decode.sv
module bwin_decode
  import bwin_pkg::*;
#(
  parameter int AW       = 8,
  parameter int WIN_BASE = 128,
  parameter int DEV_ADDR = 125,
  parameter int BHI_ADDR = 126,
  parameter int BLO_ADDR = 127,
  parameter int IDX_W    = 6
) (
  input  logic [AW-1:0]    addr,
  output bkind_e           kind,
  output logic             odd,
  output logic [IDX_W-1:0] idx
);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - AW'(WIN_BASE);
    idx = off[IDX_W:1];
    odd = addr[0];
    if (addr >= AW'(WIN_BASE))      kind = BK_WIN;
    else if (addr == AW'(DEV_ADDR)) kind = BK_DEV;
    else if (addr == AW'(BHI_ADDR)) kind = BK_BHI;
    else if (addr == AW'(BLO_ADDR)) kind = BK_BLO;
    else                            kind = BK_RSVD;
  end

endmodule

// File: rtl/bwin_ptr_regs.sv
module bwin_ptr_regs
  import bwin_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEV2_EN = 0,
  localparam int RW     = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  bkind_e        kind,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dev,
  output logic [RW-1:0] base,
  output logic          dev_ok,
  output logic [DW-1:0] rd_byte
);

  logic [DW-1:0] dev_q, dev_d;
  logic [DW-1:0] bhi_q, bhi_d;
  logic [DW-1:0] blo_q, blo_d;

  // next state
  always_comb begin
    dev_d = dev_q;
    bhi_d = bhi_q;
    blo_d = blo_q;
    if (wr_en) begin
      case (kind)
        BK_DEV:  dev_d = wdata;
        BK_BHI:  bhi_d = wdata;
        BK_BLO:  blo_d = wdata;
        default: ;
      endcase
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      bhi_q <= '0;
      blo_q <= '0;
    end else begin
      dev_q <= dev_d;
      bhi_q <= bhi_d;
      blo_q <= blo_d;
    end
  end

  // readback
  always_comb begin
    case (kind)
      BK_DEV:  rd_byte = dev_q;
      BK_BHI:  rd_byte = bhi_q;
      BK_BLO:  rd_byte = blo_q;
      default: rd_byte = '0;
    endcase
  end

  assign dev  = dev_q;
  assign base = {bhi_q, blo_q};

  generate
    if (DEV2_EN != 0) begin : g_dev_1to4
      assign dev_ok = (dev_q >= DW'(1)) && (dev_q <= DW'(4));
    end else begin : g_dev_134
      assign dev_ok = (dev_q == DW'(1)) || (dev_q == DW'(3)) || (dev_q == DW'(4));
    end
  endgenerate

  // R2: a pointer write is visible on the outputs the next cycle
  a_r2_dev_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == BK_DEV) |=> (dev == $past(wdata)));
  a_r2_base_lo_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == BK_BLO) |=> (base[DW-1:0] == $past(wdata)));
  // R3: reserved writes leave the pointers untouched
  a_r3_rsvd_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BK_RSVD) |=> ($stable(dev) && $stable(base)));

endmodule

// File: rtl/bwin_pair_ctrl.sv
module bwin_pair_ctrl #(
  parameter int DW    = 8,
  parameter int IDX_W = 6,
  localparam int RW   = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             in_win,
  input  logic             odd,
  input  logic [IDX_W-1:0] idx,
  input  logic [RW-1:0]    base,
  input  logic             dev_ok,
  input  logic [DW-1:0]    wdata,
  input  logic [RW-1:0]    mgmt_rdata,
  input  logic             mgmt_hit,
  output logic [RW-1:0]    mgmt_addr,
  output logic [RW-1:0]    mgmt_wdata,
  output logic             mgmt_we,
  output logic             mgmt_re,
  output logic [DW-1:0]    win_byte
);

  logic [DW-1:0] stage_q, stage_d;
  logic [DW-1:0] low_q, low_d;
  logic          stage_en, fetch_en;
  logic          fetch_ok;

  assign stage_en = wr && in_win && !odd;
  assign fetch_en = rd && in_win && !odd;
  assign fetch_ok = dev_ok && mgmt_hit;

  // bus side
  always_comb begin
    mgmt_addr  = base + RW'(idx);
    mgmt_wdata = {stage_q, wdata};
    mgmt_we    = wr && in_win && odd && dev_ok;
    mgmt_re    = fetch_en && dev_ok;
  end

  // next state
  always_comb begin
    stage_d = stage_q;
    low_d   = low_q;
    if (stage_en) stage_d = wdata;
    if (fetch_en) low_d = fetch_ok ? mgmt_rdata[DW-1:0] : '0;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      low_q   <= '0;
    end else begin
      stage_q <= stage_d;
      low_q   <= low_d;
    end
  end

  // byte returned for a window read
  always_comb begin
    if (odd)           win_byte = low_q;
    else if (fetch_ok) win_byte = mgmt_rdata[RW-1:DW];
    else               win_byte = '0;
  end

  // R5: the staged byte is carried as the upper half of the next pair write
  a_r5_stage_carry: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en |=> (mgmt_wdata[RW-1:DW] == $past(wdata)));
  // R6: odd reads never reach the bus
  a_r6_odd_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && in_win && odd) |-> !mgmt_re);
  // R7: a miss leaves a zero lower half behind
  a_r7_miss_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !mgmt_hit) |=> (low_q == '0));

endmodule

// File: rtl/bwin_bridge.sv
module bwin_bridge
  import bwin_pkg::*;
#(
  parameter int DEV2_EN  = 0,
  parameter int WIN_BASE = 128,
  parameter int DEV_ADDR = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  byte_addr,
  input  logic [7:0]  byte_wdata,
  input  logic        byte_wr,
  input  logic        byte_rd,
  output logic [7:0]  byte_rdata,
  output logic [7:0]  mgmt_dev,
  output logic [15:0] mgmt_addr,
  output logic [15:0] mgmt_wdata,
  output logic        mgmt_we,
  output logic        mgmt_re,
  input  logic [15:0] mgmt_rdata,
  input  logic        mgmt_hit
);

  localparam int AW       = 8;
  localparam int DW       = 8;
  localparam int RW       = 2 * DW;
  localparam int WIN_REGS = ((1 << AW) - WIN_BASE) / 2;
  localparam int IDX_W    = $clog2(WIN_REGS);

  bkind_e           kind;
  logic             odd;
  logic [IDX_W-1:0] idx;
  logic             rd_fire;
  logic             in_win;
  logic [RW-1:0]    base;
  logic             dev_ok;
  logic [DW-1:0]    ptr_byte, win_byte;
  logic [DW-1:0]    rdata_q, rdata_d;

  // a write wins over a read in the same cycle
  assign rd_fire = byte_rd && !byte_wr;
  assign in_win  = (kind == BK_WIN);

  bwin_decode #(
    .AW(AW), .WIN_BASE(WIN_BASE), .DEV_ADDR(DEV_ADDR),
    .BHI_ADDR(DEV_ADDR + 1), .BLO_ADDR(DEV_ADDR + 2), .IDX_W(IDX_W)
  ) u_dec (
    .addr(byte_addr), .kind(kind), .odd(odd), .idx(idx)
  );

  bwin_ptr_regs #(.DW(DW), .DEV2_EN(DEV2_EN)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_wr), .kind(kind),
    .wdata(byte_wdata), .dev(mgmt_dev), .base(base),
    .dev_ok(dev_ok), .rd_byte(ptr_byte)
  );

  bwin_pair_ctrl #(.DW(DW), .IDX_W(IDX_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .wr(byte_wr), .rd(rd_fire),
    .in_win(in_win), .odd(odd), .idx(idx), .base(base),
    .dev_ok(dev_ok), .wdata(byte_wdata), .mgmt_rdata(mgmt_rdata),
    .mgmt_hit(mgmt_hit), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_we(mgmt_we), .mgmt_re(mgmt_re), .win_byte(win_byte)
  );

  // next read data
  always_comb begin
    rdata_d = rdata_q;
    if (rd_fire) rdata_d = in_win ? win_byte : ptr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign byte_rdata = rdata_q;

  // R5: bus writes only come from odd window byte writes
  a_r5_we_on_odd: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_we |-> (byte_wr && byte_addr[0] && byte_addr >= AW'(WIN_BASE)));
  // R6: never read and write the register space together
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mgmt_we && mgmt_re));
  // R8: unsupported device IDs 0 and above 4 keep the bus quiet
  a_r8_baddev_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_dev == 8'd0 || mgmt_dev > 8'd4) |-> !(mgmt_we || mgmt_re));
  // R3: reserved byte reads return zero
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && byte_addr < AW'(DEV_ADDR)) |=> (byte_rdata == '0));
  // R9: read data changes only after an accepted read
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(byte_rdata));

endmodule

// File: tb/sim_bwin_bridge.sv
module sim_bwin_bridge;

  logic        clk;
  logic        rst_n;
  logic [7:0]  byte_addr, byte_wdata, byte_rdata, mgmt_dev;
  logic        byte_wr, byte_rd;
  logic [15:0] mgmt_addr, mgmt_wdata, mgmt_rdata;
  logic        mgmt_we, mgmt_re, mgmt_hit;

  int n_chk, n_fail, we_cnt, re_cnt;
  logic [15:0] last_waddr, last_wdata;
  logic [15:0] mem [64];
  logic [7:0]  rv;
  bit          done;

  bwin_bridge u0 (
    .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .byte_wr(byte_wr), .byte_rd(byte_rd), .byte_rdata(byte_rdata),
    .mgmt_dev(mgmt_dev), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_we(mgmt_we), .mgmt_re(mgmt_re), .mgmt_rdata(mgmt_rdata),
    .mgmt_hit(mgmt_hit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // register-space model: C000h..C03Fh exist, miss data is non-zero
  assign mgmt_hit   = (mgmt_addr[15:6] == 10'h300);
  assign mgmt_rdata = mgmt_hit ? mem[mgmt_addr[5:0]] : 16'hDEAD;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'h0;
      we_cnt <= 0;
      re_cnt <= 0;
    end else begin
      if (mgmt_we) begin
        we_cnt     <= we_cnt + 1;
        last_waddr <= mgmt_addr;
        last_wdata <= mgmt_wdata;
        if (mgmt_hit) mem[mgmt_addr[5:0]] <= mgmt_wdata;
      end
      if (mgmt_re) re_cnt <= re_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    byte_addr = a; byte_wdata = d; byte_wr = 1'b1;
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    byte_addr = a; byte_rd = 1'b1;
    @(negedge clk);
    byte_rd = 1'b0;
    d = byte_rdata;
  endtask

  task automatic t_reset;
    chk("R1 rdata", byte_rdata, 8'h00);
    chk("R1 strobes", {30'd0, mgmt_we, mgmt_re}, 32'd0);
    brd(8'h7D, rv); chk("R1 dev", rv, 8'h00);
    brd(8'h7E, rv); chk("R1 bhi", rv, 8'h00);
    brd(8'h7F, rv); chk("R1 blo", rv, 8'h00);
    chk("R1 no bus", we_cnt + re_cnt, 0);
  endtask

  task automatic t_pointers;
    bwr(8'h7D, 8'h01); bwr(8'h7E, 8'hC0); bwr(8'h7F, 8'h00);
    brd(8'h7D, rv); chk("R2 dev", rv, 8'h01);
    brd(8'h7E, rv); chk("R2 bhi", rv, 8'hC0);
    brd(8'h7F, rv); chk("R2 blo", rv, 8'h00);
  endtask

  task automatic t_reserved;
    bwr(8'h00, 8'hAA); bwr(8'h7C, 8'h55);
    brd(8'h00, rv); chk("R3 rd 0", rv, 8'h00);
    brd(8'h7C, rv); chk("R3 rd 124", rv, 8'h00);
    chk("R3 no bus wr", we_cnt, 0);
    brd(8'h7D, rv); chk("R3 dev kept", rv, 8'h01);
    brd(8'h7F, rv); chk("R3 blo kept", rv, 8'h00);
  endtask

  task automatic t_window_write;
    bwr(8'h80, 8'h12);
    chk("R5 even staged only", we_cnt, 0);
    bwr(8'h81, 8'h34);
    chk("R5 one write", we_cnt, 1);
    chk("R5 pair data", last_wdata, 16'h1234);
    chk("R4 addr first", last_waddr, 16'hC000);
    bwr(8'hFE, 8'hAB); bwr(8'hFF, 8'hCD);
    chk("R4 addr last", last_waddr, 16'hC03F);
    chk("R5 last data", last_wdata, 16'hABCD);
  endtask

  task automatic t_window_read;
    int r0;
    r0 = re_cnt;
    brd(8'h80, rv); chk("R6 upper", rv, 8'h12);
    chk("R6 one bus read", re_cnt, r0 + 1);
    bwr(8'h80, 8'h56); bwr(8'h81, 8'h78);
    brd(8'h81, rv); chk("R6 latched lower", rv, 8'h34);
    chk("R6 odd no bus", re_cnt, r0 + 1);
    brd(8'hFE, rv); chk("R6 upper 63", rv, 8'hAB);
    brd(8'hFF, rv); chk("R6 lower 63", rv, 8'hCD);
    brd(8'h80, rv); chk("R6 new upper", rv, 8'h56);
    brd(8'h81, rv); chk("R6 new lower", rv, 8'h78);
  endtask

  task automatic t_miss;
    bwr(8'h7E, 8'h10); bwr(8'h7F, 8'h00);
    brd(8'h82, rv); chk("R7 miss upper", rv, 8'h00);
    brd(8'h83, rv); chk("R7 miss lower", rv, 8'h00);
  endtask

  task automatic t_device;
    int w0, r0;
    bwr(8'h7E, 8'hC0); bwr(8'h7F, 8'h00); bwr(8'h7D, 8'h02);
    w0 = we_cnt; r0 = re_cnt;
    bwr(8'h80, 8'h11); bwr(8'h81, 8'h22);
    chk("R8 dev2 no write", we_cnt, w0);
    brd(8'h80, rv); chk("R8 dev2 reads 0", rv, 8'h00);
    chk("R8 dev2 no read", re_cnt, r0);
    bwr(8'h7D, 8'h00);
    brd(8'h80, rv); chk("R8 dev0 reads 0", rv, 8'h00);
    bwr(8'h7D, 8'h03);
    brd(8'h80, rv); chk("R8 dev3 served", rv, 8'h56);
  endtask

  task automatic t_wrap;
    bwr(8'h7D, 8'h01); bwr(8'h7E, 8'hFF); bwr(8'h7F, 8'hFF);
    bwr(8'h82, 8'h9A); bwr(8'h83, 8'hBC);
    chk("R4 wrap addr", last_waddr, 16'h0000);
    chk("R4 wrap data", last_wdata, 16'h9ABC);
  endtask

  task automatic t_collision;
    int r0;
    bwr(8'h7E, 8'hC0); bwr(8'h7F, 8'h00);
    brd(8'h80, rv); chk("R9 setup", rv, 8'h56);
    r0 = re_cnt;
    @(negedge clk);
    byte_addr = 8'h7D; byte_wdata = 8'h04; byte_wr = 1'b1; byte_rd = 1'b1;
    @(negedge clk);
    byte_wr = 1'b0; byte_rd = 1'b0;
    chk("R9 rdata held", byte_rdata, 8'h56);
    @(negedge clk);
    byte_addr = 8'h80; byte_wdata = 8'h00; byte_wr = 1'b1; byte_rd = 1'b1;
    @(negedge clk);
    byte_wr = 1'b0; byte_rd = 1'b0;
    chk("R9 no bus read", re_cnt, r0);
    brd(8'h7D, rv); chk("R9 write done", rv, 8'h04);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    byte_addr = '0; byte_wdata = '0; byte_wr = 1'b0; byte_rd = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointers();
    t_reserved();
    t_window_write();
    t_window_read();
    t_miss();
    t_device();
    t_wrap();
    t_collision();
    finish_run();
  end

endmodule